// File: doc/BRIEF.md
# Serial-Configured Memory Read Router

This block accepts a command one bit per clock on a single serial line. The command is framed by a start strobe. Its leading bits name one of four output channels, and the bits after them give a memory address of any length. When the strobe drops, the block issues exactly one read to an external synchronous byte memory. One clock later it captures the returned byte into the register of the named channel. That register holds its byte until a later command to the same channel replaces it, or until reset clears it.

The four channel registers are presented on a shared output bus only during a one-clock completion pulse. At all other times the bus reads zero. A new command may begin in the clock right after the pulse. The memory port has a 16-bit address, a read enable and a write-enable that never asserts.

Top module: `serial_read_router`

## Requirements
- R1: While `start` is high, the first two bits sampled on `sin` form the channel number, first bit as the MSB. Channel k owns bits [8k+7:8k] of `chan_out`.
- R2: Every bit sampled after the channel number, while `start` stays high, is an address bit. It enters at the LSB, so the earliest address bit is the most significant one sent.
- R3: An address shorter than 16 bits is zero-extended in the upper bits, and zero address bits give address 0. When more than 16 bits are sent, only the last 16 are kept.
- R4: A channel register keeps its byte across commands that name other channels. A later command naming the same channel overwrites it.
- R5: The returned byte is written only into the named channel's register. The other three are unchanged.
- R6: `done` is high for exactly one clock, in the third clock after the first clock in which `start` is sampled low. `chan_out` shows all four registers during that clock and is zero whenever `done` is low.
- R7: `mem_en` is high for exactly one clock per command, in the clock after the first low `start`, with the final address on `mem_addr`. `mem_we` is always 0.
- R8: The byte on `mem_rdata` one clock after `mem_en` is the value stored.
- R9: A synchronous reset in any phase (capture, read or wait) clears all four registers and returns to idle. No enable or done pulse follows from the interrupted command.
- R10: A new command may raise `start` in the clock right after `done` and is served in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High while serial command bits are valid |
| sin | input | 1 | Serial command bit |
| mem_rdata | input | DATA_W (8) | Byte returned by memory, one clock after enable |
| mem_addr | output | ADDR_W (16) | Read address |
| mem_en | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable, held at 0 |
| done | output | 1 | One-clock completion pulse |
| chan_out | output | 4*DATA_W (32) | Channel registers, shown only while `done` is high |

## Verification
The four channels are each written with a full 16-bit address. This separates the channel decode and bit ordering from one another. Addresses of zero, five and twenty bits show that zero-extension and truncation to the last sixteen bits both work. The all-ones address shows the top bit is not dropped. Overwrites and back-to-back commands show that registers stick and that the pulse ends cleanly. Resets injected during capture and during the memory wait show that no stale write or pulse leaks out.

// File: rtl/srr_pkg.sv
package srr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_REQ,
        ST_WAIT,
        ST_SHOW
    } srr_state_e;

    typedef struct packed {
        logic begin_cmd;   // first serial bit of a command
        logic shift;       // further serial bit of the same command
        logic mem_req;     // read request to memory
        logic wr_en;       // read data valid, load channel register
        logic show;        // completion pulse
    } srr_ctrl_t;

    function automatic srr_state_e srr_next(srr_state_e s, logic start);
        case (s)
            ST_IDLE: return start ? ST_CAPT : ST_IDLE;
            ST_CAPT: return start ? ST_CAPT : ST_REQ;
            ST_REQ:  return ST_WAIT;
            ST_WAIT: return ST_SHOW;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic srr_ctrl_t srr_decode(srr_state_e s, logic start);
        srr_ctrl_t c;
        c.begin_cmd = (s == ST_IDLE) && start;
        c.shift     = (s == ST_CAPT) && start;
        c.mem_req   = (s == ST_REQ);
        c.wr_en     = (s == ST_WAIT);
        c.show      = (s == ST_SHOW);
        return c;
    endfunction

endpackage

// File: rtl/srr_fsm.sv
module srr_fsm
    import srr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output srr_ctrl_t ctrl
);

    srr_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= srr_next(state_q, start);
    end

    always_comb ctrl = srr_decode(state_q, start);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.show |=> !ctrl.show);

    // R8
    req_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_req |=> ctrl.wr_en);

    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_req |=> !ctrl.mem_req);

endmodule

// File: rtl/srr_capture.sv
module srr_capture #(
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              begin_cmd,
    input  logic              shift,
    input  logic              sin,
    output logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);

    localparam int CNT_W = $clog2(SEL_W + 1);

    logic [CNT_W-1:0] sel_cnt_q;
    logic             sel_full;

    assign sel_full = (sel_cnt_q >= CNT_W'(SEL_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= '0;
            addr      <= '0;
            sel_cnt_q <= '0;
        end else if (begin_cmd) begin
            sel       <= SEL_W'(sin);
            addr      <= '0;
            sel_cnt_q <= CNT_W'(1);
        end else if (shift) begin
            if (!sel_full) begin
                sel       <= SEL_W'({sel, sin});
                sel_cnt_q <= sel_cnt_q + CNT_W'(1);
            end else begin
                addr <= ADDR_W'({addr, sin});
            end
        end
    end

    // R3
    addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        begin_cmd |=> addr == '0);

endmodule

// File: rtl/srr_bank.sv
module srr_bank #(
    parameter int NCH    = 4,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  show,
    input  logic [SEL_W-1:0]      sel,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NCH*DATA_W-1:0] bus
);

    logic [DATA_W-1:0] reg_q [NCH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst)
                reg_q[i] <= '0;
            else if (wr_en && (sel == SEL_W'(i)))
                reg_q[i] <= wdata;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign bus[g*DATA_W +: DATA_W] = show ? reg_q[g] : '0;

        // R5
        other_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel != SEL_W'(g)) |=> $stable(reg_q[g]));

        // R4
        idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(reg_q[g]));

        // R9
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> reg_q[g] == '0);
    end

endmodule

// File: rtl/serial_read_router.sv
module serial_read_router
    import srr_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic                              sin,
    input  logic [DATA_W-1:0]                 mem_rdata,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic                              mem_en,
    output logic                              mem_we,
    output logic                              done,
    output logic [(2**SEL_W)*DATA_W-1:0]      chan_out
);

    localparam int NCH = 2 ** SEL_W;

    srr_ctrl_t         ctrl;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] addr;

    srr_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl)
    );

    srr_capture #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .begin_cmd (ctrl.begin_cmd),
        .shift     (ctrl.shift),
        .sin       (sin),
        .sel       (sel),
        .addr      (addr)
    );

    srr_bank #(.NCH(NCH), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctrl.wr_en),
        .show  (ctrl.show),
        .sel   (sel),
        .wdata (mem_rdata),
        .bus   (chan_out)
    );

    assign mem_addr = addr;
    assign mem_en   = ctrl.mem_req;
    assign mem_we   = 1'b0;
    assign done     = ctrl.show;

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> chan_out == '0);

    // R7
    en_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ##2 done);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> $stable(mem_addr));

endmodule

// File: tb/serial_read_router_tb.sv
module serial_read_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sin = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_en;
    logic        mem_we;
    logic        done;
    logic [31:0] chan_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_ch [4];

    serial_read_router u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .sin       (sin),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .done      (done),
        .chan_out  (chan_out)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return (a[7:0] ^ {a[11:8], a[15:12]}) + 8'h3C;
    endfunction

    always @(posedge clk) if (mem_en) mem_rdata <= mem_byte(mem_addr);

    function automatic logic [31:0] exp_bus();
        return {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(logic [1:0] sel, logic [31:0] addr, int nb);
        @(negedge clk);
        check("R6 done low before command", {31'd0, done}, 32'd0);
        start = 1'b1; sin = sel[1];
        @(negedge clk); sin = sel[0];
        for (int i = nb - 1; i >= 0; i--) begin
            @(negedge clk); sin = addr[i];
        end
        @(negedge clk); start = 1'b0; sin = 1'b0;
    endtask

    task automatic run_cmd(string tag, logic [1:0] sel, logic [31:0] addr, int nb);
        logic [31:0] m;
        logic [15:0] ea;
        m  = (nb >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
        ea = 16'(addr & m);
        send_bits(sel, addr, nb);
        check("R6 done low in first idle-start clock", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R7 mem_en pulse", {31'd0, mem_en}, 32'd1);
        check({tag, " address"}, {16'd0, mem_addr}, {16'd0, ea});
        check("R7 mem_we low", {31'd0, mem_we}, 32'd0);
        @(negedge clk);
        check("R7 mem_en single", {31'd0, mem_en}, 32'd0);
        check("R6 outputs zero without done", chan_out, 32'd0);
        exp_ch[sel] = mem_byte(ea);
        @(negedge clk);
        check("R6 done asserted", {31'd0, done}, 32'd1);
        check({tag, " R8 channel bus"}, chan_out, exp_bus());
    endtask

    task automatic t_reset_state();
        check("R9 reset done", {31'd0, done}, 32'd0);
        check("R9 reset mem_en", {31'd0, mem_en}, 32'd0);
        check("R7 reset mem_we", {31'd0, mem_we}, 32'd0);
        check("R6 reset bus", chan_out, 32'd0);
    endtask

    task automatic t_all_channels();
        run_cmd("R1 R5 ch0", 2'd0, 32'h1234, 16);
        run_cmd("R1 R5 ch1", 2'd1, 32'hA5C3, 16);
        run_cmd("R1 R5 ch2", 2'd2, 32'h0F0E, 16);
        run_cmd("R1 R2 ch3", 2'd3, 32'h8001, 16);
    endtask

    task automatic t_short_addr();
        run_cmd("R3 empty address", 2'd1, 32'h0, 0);
        run_cmd("R3 five-bit address", 2'd2, 32'h16, 5);
    endtask

    task automatic t_max_and_long();
        run_cmd("R2 max address", 2'd0, 32'hFFFF, 16);
        run_cmd("R3 twenty-bit address keeps last 16", 2'd3, 32'hABCDE, 20);
    endtask

    task automatic t_overwrite();
        run_cmd("R4 first write", 2'd2, 32'h0042, 16);
        run_cmd("R4 overwrite", 2'd2, 32'h7700, 16);
    endtask

    task automatic t_back_to_back();
        run_cmd("R10 first", 2'd1, 32'h0033, 8);
        @(negedge clk);
        check("R6 done one clock", {31'd0, done}, 32'd0);
        start = 1'b1; sin = 1'b0;
        @(negedge clk); sin = 1'b0;
        for (int i = 2; i >= 0; i--) begin
            @(negedge clk); sin = 1'(3'b101 >> i);
        end
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check("R10 back-to-back mem_en", {31'd0, mem_en}, 32'd1);
        check("R10 back-to-back addr", {16'd0, mem_addr}, 32'd5);
        exp_ch[0] = mem_byte(16'd5);
        @(negedge clk);
        @(negedge clk);
        check("R10 back-to-back done", {31'd0, done}, 32'd1);
        check("R10 back-to-back bus", chan_out, exp_bus());
    endtask

    task automatic idle_quiet(string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req, {30'd0, mem_en, done}, 32'd0);
        end
    endtask

    task automatic t_reset_capture();
        @(negedge clk); start = 1'b1; sin = 1'b1;
        @(negedge clk); sin = 1'b1;
        @(negedge clk); sin = 1'b0;
        @(negedge clk); rst = 1'b1; start = 1'b0;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_ch[i] = 8'h00;
        idle_quiet("R9 no pulse after capture reset");
        run_cmd("R9 clear visible after capture reset", 2'd1, 32'h0101, 16);
    endtask

    task automatic t_reset_wait();
        send_bits(2'd3, 32'h00F0, 16);
        @(negedge clk);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_ch[i] = 8'h00;
        idle_quiet("R9 no pulse after wait reset");
        run_cmd("R9 clear visible after wait reset", 2'd2, 32'h2222, 16);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_ch[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_all_channels();
        t_short_addr();
        t_max_and_long();
        t_overwrite();
        t_back_to_back();
        t_reset_capture();
        t_reset_wait();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule